// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes a two-channel serial audio stream and turns it into parallel sample words. All of its logic runs on the incoming bit clock. Two other inputs carry the stream: a frame clock that tells the two channels apart, and a single data line. Static configuration inputs set the framing, the word length and the frame-clock polarity.

The framing is either right-justified with MSB first or I2S. In right-justified framing the word ends on the last bit clock before a frame-clock transition. In I2S framing the word starts one bit clock after the transition.

Every word is sign-extended to 24 bits. A one-cycle strobe marks the moment a full left/right pair is ready. In right-justified framing the receiver watches how many bit clocks make up each frame. When a frame holds exactly 32 bit clocks, it handles the following frames as 16-bit data, whatever word length is configured.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, `left_sample` and `right_sample` read zero and `sample_valid` is low until the first complete frame has been received.
- R2: With `fmt_sel` = 0 (right-justified), a channel's word is the last N data bits sampled before the frame-clock transition that ends that channel's half-frame. The MSB arrives first, and all earlier bits of the half-frame are ignored.
- R3: With `fmt_sel` = 1 (I2S), a channel's word is the N data bits sampled on the N bit clocks that follow the frame-clock transition. The MSB arrives first, and all later bits of the half-frame are ignored.
- R4: N follows `wl_code` as follows: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24 and 2'b11 gives 18.
- R5: With `frame_pol` = 0, a high frame clock carries the left channel and a low frame clock carries the right channel. With `frame_pol` = 1, the roles are swapped.
- R6: Output words are the received N-bit two's-complement value, sign-extended to 24 bits.
- R7: `sample_valid` is a one-cycle pulse in the cycle the right word is updated, once per frame. A frame is a left half-frame followed by a right half-frame. `right_sample` changes only in that cycle, and `left_sample` holds steady during it.
- R8: In right-justified framing, take a frame (left plus right half-frame) of exactly 32 bit clocks. Every word captured after the transition that closes that frame uses N = 16, whatever `wl_code` holds.
- R9: The 16-bit override of R8 is lifted in the same way. Once a frame whose length is not 32 closes, the words that follow use the N given by `wl_code` again.
- R10: In packed I2S framing (half-frame length equal to N), the LSB falls on the first bit clock of the next half-frame. It is still assigned to the word it belongs to, and that word goes to the channel of the half-frame it started in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_clk | input | 1 | Frame clock selecting the channel of each half-frame |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 1 | Framing: 0 right-justified, 1 I2S |
| wl_code | input | 2 | Word-length code (see R4) |
| frame_pol | input | 1 | Frame-clock polarity (see R5) |
| left_sample | output | 24 | Last left word, sign-extended |
| right_sample | output | 24 | Last right word, sign-extended |
| sample_valid | output | 1 | One-cycle pulse when a left/right pair is complete |

## Verification
The sweep covers every combination of framing, polarity and word-length code. For each combination it uses three half-frame lengths: packed, a few bits longer than the word, and 32 bits. Filler bits alternate, so a capture window that slips by one bit clock gives a different value. The packed I2S case is the one where the LSB sits on the next transition; a design that closes its window at that transition would lose the LSB or file the word under the wrong channel. The override case first sends 32-bit frames with a 24-bit setting, then widens the frames again. A design that applied the override within the measuring frame, never applied it, or never released it would produce words of the wrong width in the frames next to each change.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  localparam logic FMT_RJ  = 1'b0;
  localparam logic FMT_I2S = 1'b1;

  localparam int unsigned OVR_WORD_BITS = 16;

  // word-length code to number of bits
  function automatic logic [4:0] wl_bits(input logic [1:0] code);
    case (code)
      2'b00:   wl_bits = 5'd16;
      2'b01:   wl_bits = 5'd20;
      2'b10:   wl_bits = 5'd24;
      default: wl_bits = 5'd18;
    endcase
  endfunction

endpackage

// File: rtl/asrx_frame_track.sv
// Frame-clock edge detection, half-frame length measurement and
// detection of the 32-clock (16-bit packed) frame.
module asrx_frame_track #(
  parameter int CNT_W    = 7,
  parameter int PACK_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic frame_pol,
  output logic edge_now,
  output logic left_now,
  output logic prev_left,
  output logic started,
  output logic packed16
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             primed_q, primed_d;
  logic             lrck_q, lrck_d;
  logic             started_q, started_d;
  logic             started2_q, started2_d;
  logic [CNT_W-1:0] hcnt_q, hcnt_d;
  logic [CNT_W-1:0] plen_q, plen_d;
  logic             pk_q, pk_d;
  logic [SUM_W-1:0] frame_len;

  assign edge_now  = primed_q && (frame_clk != lrck_q);
  assign left_now  = frame_clk ^ frame_pol;
  assign prev_left = lrck_q ^ frame_pol;
  assign started   = started_q;
  assign packed16  = pk_q;
  assign frame_len = {1'b0, plen_q} + {1'b0, hcnt_q};

  always_comb begin
    primed_d   = 1'b1;
    lrck_d     = frame_clk;
    started_d  = started_q | edge_now;
    started2_d = started2_q | (edge_now & started_q);
    plen_d     = plen_q;
    pk_d       = pk_q;
    if (edge_now) begin
      hcnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
      plen_d = hcnt_q;
      // entering a left half closes a left+right frame
      if (left_now && started2_q) begin
        pk_d = (frame_len == SUM_W'(PACK_LEN));
      end
    end else if (hcnt_q == CNT_MAX) begin
      hcnt_d = hcnt_q;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      lrck_q     <= 1'b0;
      started_q  <= 1'b0;
      started2_q <= 1'b0;
      hcnt_q     <= '0;
      plen_q     <= '0;
      pk_q       <= 1'b0;
    end else begin
      primed_q   <= primed_d;
      lrck_q     <= lrck_d;
      started_q  <= started_d;
      started2_q <= started2_d;
      hcnt_q     <= hcnt_d;
      plen_q     <= plen_d;
      pk_q       <= pk_d;
    end
  end

endmodule

// File: rtl/asrx_shifter.sv
// Free-running serial-in shift register, newest bit at index 0.
module asrx_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] sr
);

  logic [W-1:0] sr_q, sr_d;

  assign sr = sr_q;

  always_comb begin
    sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

endmodule

// File: rtl/asrx_capture.sv
// Word window selection for both framings, sign extension and output
// registers.
module asrx_capture
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_sel,
  input  logic [1:0]          wl_code,
  input  logic                packed16,
  input  logic                edge_now,
  input  logic                started,
  input  logic                left_now,
  input  logic                prev_left,
  input  logic [SAMPLE_W-1:0] shreg,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid
);

  localparam int DCNT_W = $clog2(SAMPLE_W + 1);

  logic [DCNT_W-1:0]   eff_n;
  logic [DCNT_W-1:0]   dcnt_q, dcnt_d;
  logic                win_left_q, win_left_d;
  logic                cap, cap_left;
  logic [SAMPLE_W-1:0] raw, ext;
  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic                valid_q, valid_d;

  assign left_sample  = left_q;
  assign right_sample = right_q;
  assign sample_valid = valid_q;

  // effective word length
  always_comb begin
    if ((fmt_sel == FMT_RJ) && packed16) begin
      eff_n = DCNT_W'(OVR_WORD_BITS);
    end else begin
      eff_n = DCNT_W'(wl_bits(wl_code));
    end
  end

  // I2S data window: counts bits after the frame edge
  always_comb begin
    dcnt_d     = dcnt_q;
    win_left_d = win_left_q;
    if (edge_now && (fmt_sel == FMT_I2S)) begin
      dcnt_d     = DCNT_W'(1);
      win_left_d = left_now;
    end else if (cap) begin
      dcnt_d = '0;
    end else if (dcnt_q != '0) begin
      dcnt_d = dcnt_q + 1'b1;
    end
  end

  always_comb begin
    if (fmt_sel == FMT_I2S) begin
      cap      = (dcnt_q != '0) && (dcnt_q == eff_n);
      cap_left = win_left_q;
      raw      = {shreg[SAMPLE_W-2:0], ser_data};
    end else begin
      cap      = edge_now && started;
      cap_left = prev_left;
      raw      = shreg;
    end
  end

  // sign extension from eff_n bits
  always_comb begin
    for (int i = 0; i < SAMPLE_W; i++) begin
      ext[i] = (DCNT_W'(i) < eff_n) ? raw[i] : raw[eff_n - 1'b1];
    end
  end

  always_comb begin
    left_d  = (cap && cap_left)  ? ext : left_q;
    right_d = (cap && !cap_left) ? ext : right_q;
    valid_d = cap && !cap_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q     <= '0;
      win_left_q <= 1'b0;
      left_q     <= '0;
      right_q    <= '0;
      valid_q    <= 1'b0;
    end else begin
      dcnt_q     <= dcnt_d;
      win_left_q <= win_left_d;
      left_q     <= left_d;
      right_q    <= right_d;
      valid_q    <= valid_d;
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 7,
  parameter int PACK_LEN = 32
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic                fmt_sel,
  input  logic [1:0]          wl_code,
  input  logic                frame_pol,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   edge_now, left_now, prev_left, started, packed16;
  logic [SAMPLE_W-1:0]    shreg;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  asrx_frame_track #(
    .CNT_W    (CNT_W),
    .PACK_LEN (PACK_LEN)
  ) u_track (
    .clk       (bit_clk),
    .rst_n     (rst_int_n),
    .frame_clk (frame_clk),
    .frame_pol (frame_pol),
    .edge_now  (edge_now),
    .left_now  (left_now),
    .prev_left (prev_left),
    .started   (started),
    .packed16  (packed16)
  );

  asrx_shifter #(
    .W (SAMPLE_W)
  ) u_shift (
    .clk   (bit_clk),
    .rst_n (rst_int_n),
    .din   (ser_data),
    .sr    (shreg)
  );

  asrx_capture #(
    .SAMPLE_W (SAMPLE_W)
  ) u_cap (
    .clk          (bit_clk),
    .rst_n        (rst_int_n),
    .fmt_sel      (fmt_sel),
    .wl_code      (wl_code),
    .packed16     (packed16),
    .edge_now     (edge_now),
    .started      (started),
    .left_now     (left_now),
    .prev_left    (prev_left),
    .shreg        (shreg),
    .ser_data     (ser_data),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid)
  );

endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          wl_code,
  input logic [SAMPLE_W-1:0] left_sample,
  input logic [SAMPLE_W-1:0] right_sample,
  input logic                sample_valid
);

  AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R7

  AST_RIGHT_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_sample) |-> sample_valid); // R7

  AST_LEFT_HELD_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $stable(left_sample)); // R7

  AST_SIGN_EXT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && ($past(wl_code) == 2'b00)) |->
      (($countones(right_sample[SAMPLE_W-1:15]) == 0) ||
       ($countones(right_sample[SAMPLE_W-1:15]) == SAMPLE_W - 15))); // R6

endmodule

bind audio_serial_rx asrx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (bit_clk),
  .rst_n        (rst_n),
  .wl_code      (wl_code),
  .left_sample  (left_sample),
  .right_sample (right_sample),
  .sample_valid (sample_valid)
);

// File: tb/audio_serial_rx_test.sv
`timescale 1ns/1ps
module audio_serial_rx_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_clk, ser_data, fmt_sel, frame_pol;
  logic [1:0]  wl_code;
  logic [23:0] left_sample, right_sample;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;
  int vcnt   = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic        prev_lsb;
  string       tag;

  int          nfr;
  int          fh [0:7];
  int          ftx[0:7];
  int          fn [0:7];
  bit          fok[0:7];
  logic [23:0] exp_l[0:7];
  logic [23:0] exp_r[0:7];
  bit          exp_ok[0:7];

  always #2.5 clk = ~clk;

  audio_serial_rx uut (
    .bit_clk      (clk),
    .rst_n        (rst_n),
    .frame_clk    (frame_clk),
    .ser_data     (ser_data),
    .fmt_sel      (fmt_sel),
    .wl_code      (wl_code),
    .frame_pol    (frame_pol),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] sx(input logic [31:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic int nbits(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 18;
    endcase
  endfunction

  // output monitor: one entry per valid pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sample_valid === 1'b1) begin
      if (vcnt < 8 && exp_ok[vcnt]) begin
        check(left_sample == exp_l[vcnt], {tag, " left word"}, {8'h0, left_sample}, {8'h0, exp_l[vcnt]});
        check(right_sample == exp_r[vcnt], {tag, " right word"}, {8'h0, right_sample}, {8'h0, exp_r[vcnt]});
      end
      vcnt++;
    end
  end

  task automatic send_bit(input logic lvl, input logic d);
    @(negedge clk);
    frame_clk = lvl;
    ser_data  = d;
  endtask

  task automatic send_half(input bit is_left, input logic [31:0] w, input int h, input int n);
    logic lvl;
    logic d;
    lvl = is_left ^ frame_pol;
    for (int j = 0; j < h; j++) begin
      d = j[0];  // alternating filler
      if (fmt_sel == 1'b0) begin
        if (j >= h - n) d = w[h-1-j];
      end else begin
        if (j == 0) d = (h == n) ? prev_lsb : 1'b0;
        else if (j <= n) d = w[n-j];
      end
      send_bit(lvl, d);
    end
    prev_lsb = (fmt_sel == 1'b1 && h == n) ? w[0] : 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_clk = frame_pol;
    ser_data  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs at rest after reset
    check(left_sample == 24'h0 && right_sample == 24'h0 && sample_valid == 1'b0,
          "R1 reset state", {8'h0, left_sample | right_sample}, 32'h0);
  endtask

  task automatic run_cfg(input bit f, input bit p, input logic [1:0] wl, input string t);
    logic [31:0] lw, rw;
    fmt_sel = f; frame_pol = p; wl_code = wl;
    do_reset();
    vcnt = 0;
    tag  = t;
    prev_lsb = 1'b0;
    repeat (5) send_bit(p, 1'b0);  // idle at right-channel level
    for (int fr = 0; fr < nfr; fr++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223; lw = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rw = lcg;
      exp_l[fr]  = sx(lw, fn[fr]);
      exp_r[fr]  = sx(rw, fn[fr]);
      exp_ok[fr] = fok[fr];
      send_half(1'b1, lw, fh[fr], ftx[fr]);
      send_half(1'b0, rw, fh[fr], ftx[fr]);
    end
    send_bit(1'b1 ^ p, prev_lsb);  // closing frame edge
    repeat (3) send_bit(1'b1 ^ p, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    // R7: one valid per frame
    check(vcnt == nfr, {t, " R7 valid count"}, vcnt, nfr);
  endtask

  initial begin
    rst_n = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    fmt_sel = 1'b0; frame_pol = 1'b0; wl_code = 2'b00;
    for (int i = 0; i < 8; i++) exp_ok[i] = 1'b0;

    // sweep: framing x polarity x word length x half-frame length
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < 2; p++) begin
        for (int wl = 0; wl < 4; wl++) begin
          for (int hv = 0; hv < 3; hv++) begin
            int n;
            int h;
            n = nbits(2'(wl));
            h = (hv == 0) ? n : (hv == 1) ? n + 3 : 32;
            nfr = 3;
            for (int k = 0; k < 3; k++) begin
              fh[k] = h; ftx[k] = n; fn[k] = n; fok[k] = 1'b1;
            end
            if (f == 0)
              run_cfg(1'b0, p[0], 2'(wl), "R2 R4 R5 R6");
            else if (h == n)
              run_cfg(1'b1, p[0], 2'(wl), "R3 R10 R4 R5 R6");
            else
              run_cfg(1'b1, p[0], 2'(wl), "R3 R4 R5 R6");
          end
        end
      end
    end

    // R8 / R9: 16-bit override in right-justified framing with a 24-bit setting
    nfr = 5;
    fh[0] = 16; ftx[0] = 16; fn[0] = 16; fok[0] = 1'b0;  // measuring frame
    fh[1] = 16; ftx[1] = 16; fn[1] = 16; fok[1] = 1'b1;  // R8
    fh[2] = 16; ftx[2] = 16; fn[2] = 16; fok[2] = 1'b1;  // R8
    fh[3] = 32; ftx[3] = 24; fn[3] = 16; fok[3] = 1'b1;  // R9: still overridden
    fh[4] = 32; ftx[4] = 24; fn[4] = 24; fok[4] = 1'b1;  // R9: released
    run_cfg(1'b0, 1'b0, 2'b10, "R8 R9 override");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule